// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Unit

This unit sits next to a real-time calendar counter and turns its time and rollover activity into one interrupt line. Six BCD alarm bytes, held in registers, are compared with the live calendar value whenever the counter core signals a tick. A full match on all six fields latches an alarm flag. Separately, the counter core pulses one strobe for each second, minute, hour and day rollover, and each pulse latches its own periodic flag.

Software reaches the unit through a byte-wide register bus. It writes the alarm bytes, chooses which rollover drives the timer interrupt, enables either source, and clears flags by writing ones to the status register. A latched flag stays set until software clears it. Masking a source leaves its flag set. The interrupt output is registered and stays high for as long as an enabled flag remains set.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the alarm bytes, the status register and the enable register all read 0x00, and `irq` is low.
- R2: The alarm bytes sit at bus addresses 0x07 to 0x0C, in the order seconds, minutes, hours, day, month, year. Each byte reads back the value last written to it. Unmapped addresses read 0x00.
- R3: `now_time` packs the live value as seconds in [7:0], minutes in [15:8], hours in [23:16], day in [31:24], month in [39:32] and year in [47:40]. On a cycle with `tick` high, when all six bytes equal the alarm bytes, status bit 6 is set on the next clock edge. The flag is not set when any field differs, or when the fields match but no tick occurs.
- R4: Pulses on `roll_evt` bits 0, 1, 2 and 3 (second, minute, hour, day) set status bits 2, 3, 4 and 5 respectively on the next edge. Status bits 7, 1 and 0 always read 0.
- R5: The status register is at 0x10. Writing a 1 to a status bit clears that bit, and writing a 0 has no effect. When a set event and a clear land in the same cycle, the bit ends up set.
- R6: The enable register is at 0x11. Bits [1:0] select the period (00 second, 01 minute, 10 hour, 11 day). Bit 2 enables the timer interrupt and bit 3 enables the alarm interrupt. Bits 7:4 read 0.
- R7: `irq` is registered. It equals (alarm flag AND alarm enable) OR (selected periodic flag AND timer enable), as sampled one clock earlier, so it rises one edge after the flag does.
- R8: While the alarm flag is set and the alarm interrupt is enabled, `irq` stays high. It falls one edge after the flag is cleared.
- R9: Clearing an enable bit forces `irq` low but leaves the latched status flag set. Setting the enable bit again raises `irq` once more.
- R10: Periodic flags that the period field does not select have no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Strobe: the counters have just updated |
| now_time | input | 48 | Live BCD time, six bytes, seconds in the low byte |
| roll_evt | input | 4 | Rollover strobes: second, minute, hour, day |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from the address) |
| irq | output | 1 | Level interrupt |

## Verification
Any wrong internal state shows up at the ports within one or two edges. A flag that fails to latch or to clear reads back wrong at the status address on the cycle after the event or the write. One edge later it also shows on `irq`. A period select that decodes the wrong rollover raises or drops `irq` on the second edge after the strobe, and the stimulus table walks every period setting against both selected and unselected strobes to expose this. The races between a clear and a new event, and the one-edge lag of the interrupt, are each checked on the exact cycle where the requirement fixes the value.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELD_N = 6;
    localparam int ADDR_W  = 5;
    localparam int PER_N   = 4;

    localparam logic [ADDR_W-1:0] ALM_BASE  = 5'h07;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h10;
    localparam logic [ADDR_W-1:0] IEN_ADDR  = 5'h11;

    localparam int STAT_PER_LSB = 2;
    localparam int STAT_ALM_BIT = 6;

    typedef enum logic [1:0] {
        PER_SEC  = 2'b00,
        PER_MIN  = 2'b01,
        PER_HOUR = 2'b10,
        PER_DAY  = 2'b11
    } per_sel_e;

    // Enable register, bit 3 down to bit 0
    typedef struct packed {
        logic     alm_en;
        logic     tmr_en;
        per_sel_e per;
    } ien_t;

    typedef struct packed {
        logic             alm;
        logic [PER_N-1:0] per;
    } flags_t;

    function automatic logic pick_period(per_sel_e s, logic [PER_N-1:0] f);
        return f[s];
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(flags_t f);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[STAT_ALM_BIT] = f.alm;
        v[STAT_PER_LSB +: PER_N] = f.per;
        return v;
    endfunction

endpackage

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank
    import rtc_irq_pkg::*;
#(
    parameter int FIELDS = FIELD_N,
    parameter int BW     = BYTE_W,
    parameter int AW     = ADDR_W,
    parameter int BASE   = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [BW-1:0]        wdata,
    input  logic [FIELDS*BW-1:0] now_time,
    output logic [BW-1:0]        rdata,
    output logic                 rsel,
    output logic                 hit
);

    logic [FIELDS-1:0][BW-1:0] alm_q;
    logic [FIELDS-1:0]         eq;
    logic [FIELDS-1:0]         sel;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        localparam logic [AW-1:0] MY_ADDR = AW'(BASE + i);

        assign sel[i] = (addr == MY_ADDR);
        assign eq[i]  = (alm_q[i] == now_time[i*BW +: BW]);

        always_ff @(posedge clk) begin
            if (rst) begin
                alm_q[i] <= '0;
            end else if (we && sel[i]) begin
                alm_q[i] <= wdata;
            end
        end

        // R2: a write lands in the addressed byte
        a_r2_field_write: assert property (@(posedge clk) disable iff (rst)
            (we && sel[i]) |=> (alm_q[i] == $past(wdata)));
    end

    assign hit  = &eq;
    assign rsel = |sel;

    always_comb begin
        rdata = '0;
        for (int k = 0; k < FIELDS; k++) begin
            if (sel[k]) begin
                rdata = alm_q[k];
            end
        end
    end

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
    import rtc_irq_pkg::*;
#(
    parameter int NPER = PER_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPER-1:0] per_evt,
    input  logic            alm_evt,
    input  logic            clr_we,
    input  logic [NPER-1:0] clr_per,
    input  logic            clr_alm,
    output logic [NPER-1:0] per_q,
    output logic            alm_q
);

    for (genvar i = 0; i < NPER; i++) begin : g_per
        always_ff @(posedge clk) begin
            if (rst) begin
                per_q[i] <= 1'b0;
            end else if (per_evt[i]) begin
                per_q[i] <= 1'b1;
            end else if (clr_we && clr_per[i]) begin
                per_q[i] <= 1'b0;
            end
        end

        // R5: a new rollover wins over a same-cycle clear
        a_r5_per_event_wins: assert property (@(posedge clk) disable iff (rst)
            per_evt[i] |=> per_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= 1'b0;
        end else if (alm_evt) begin
            alm_q <= 1'b1;
        end else if (clr_we && clr_alm) begin
            alm_q <= 1'b0;
        end
    end

    // R5: write-one clears the alarm flag when no match arrives
    a_r5_alarm_w1c: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_alm && !alm_evt) |=> !alm_q);

    // R5: without a clear the alarm flag stays latched
    a_r5_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
        (alm_q && !(clr_we && clr_alm)) |=> alm_q);

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int FIELDS = FIELD_N,
    parameter int BW     = BYTE_W,
    parameter int AW     = ADDR_W,
    parameter int NPER   = PER_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [FIELDS*BW-1:0] now_time,
    input  logic [NPER-1:0]      roll_evt,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [BW-1:0]        bus_wdata,
    output logic [BW-1:0]        bus_rdata,
    output logic                 irq
);

    localparam int IEN_W = $bits(ien_t);

    logic [BW-1:0] alm_rdata;
    logic          alm_rsel;
    logic          alm_hit;
    logic          alm_evt;
    logic          stat_we;
    ien_t          ien_q;
    flags_t        flags;

    rtc_alarm_bank #(
        .FIELDS (FIELDS),
        .BW     (BW),
        .AW     (AW),
        .BASE   (int'(ALM_BASE))
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .now_time (now_time),
        .rdata    (alm_rdata),
        .rsel     (alm_rsel),
        .hit      (alm_hit)
    );

    assign alm_evt = tick && alm_hit;
    assign stat_we = bus_we && (bus_addr == STAT_ADDR);

    rtc_event_flags #(
        .NPER (NPER)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .per_evt (roll_evt),
        .alm_evt (alm_evt),
        .clr_we  (stat_we),
        .clr_per (bus_wdata[STAT_PER_LSB +: NPER]),
        .clr_alm (bus_wdata[STAT_ALM_BIT]),
        .per_q   (flags.per),
        .alm_q   (flags.alm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (bus_we && (bus_addr == IEN_ADDR)) begin
            ien_q <= ien_t'(bus_wdata[IEN_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= (flags.alm && ien_q.alm_en)
                || (pick_period(ien_q.per, flags.per) && ien_q.tmr_en);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (alm_rsel) begin
            bus_rdata = alm_rdata;
        end else if (bus_addr == STAT_ADDR) begin
            bus_rdata = pack_status(flags);
        end else if (bus_addr == IEN_ADDR) begin
            bus_rdata = BW'(ien_q);
        end
    end

    // R3: a tick on a full match latches the alarm flag
    a_r3_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
        alm_evt |=> flags.alm);

    // R8: an enabled, latched alarm keeps the line high
    a_r8_alarm_holds_irq: assert property (@(posedge clk) disable iff (rst)
        (flags.alm && ien_q.alm_en) |=> irq);

    // R9: with both sources masked the line stays low
    a_r9_masked_low: assert property (@(posedge clk) disable iff (rst)
        (!ien_q.alm_en && !ien_q.tmr_en) |=> !irq);

    // R7: the line cannot rise without a latched flag one edge earlier
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (!flags.alm && (flags.per == '0)) |=> !irq);

endmodule

// File: tb/sim_rtc_irq_unit.sv
module sim_rtc_irq_unit;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_ALM  = 5'h07;
    localparam logic [4:0] A_STAT = 5'h10;
    localparam logic [4:0] A_IEN  = 5'h11;

    // {period[1:0], roll[3:0], expected irq}
    localparam logic [6:0] VEC [0:7] = '{
        7'b00_0001_1, 7'b00_0010_0, 7'b01_0010_1, 7'b10_0100_1,
        7'b11_1000_1, 7'b11_0111_0, 7'b01_1111_1, 7'b10_1011_0
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [47:0] now_time = '0;
    logic [3:0]  roll_evt = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] alm_val [0:5] = '{8'h30, 8'h15, 8'h09, 8'h21, 8'h06, 8'h25};
    logic [47:0] match_time;

    rtc_irq_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .now_time  (now_time),
        .roll_evt  (roll_evt),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_roll(input logic [3:0] r);
        @(negedge clk); roll_evt = r;
        @(negedge clk); roll_evt = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(A_STAT, v); check("R1 status", v, 8'h00);
        rd(A_IEN, v);  check("R1 enable", v, 8'h00);
        rd(A_ALM, v);  check("R1 alarm sec", v, 8'h00);

        // R2 alarm bytes
        for (int i = 0; i < 6; i++) wr(A_ALM + 5'(i), alm_val[i]);
        for (int i = 0; i < 6; i++) begin
            rd(A_ALM + 5'(i), v); check("R2 alarm readback", v, alm_val[i]);
        end
        rd(5'h00, v); check("R2 unmapped", v, 8'h00);

        // R6 enable register field width
        wr(A_IEN, 8'hFF);
        rd(A_IEN, v); check("R6 enable readback", v, 8'h0F);
        wr(A_IEN, 8'h00);
        @(negedge clk);

        // R4, R7, R10 table walk
        for (int e = 0; e < 8; e++) begin
            logic [1:0] sel;
            logic [3:0] rl;
            sel = VEC[e][6:5];
            rl  = VEC[e][4:1];
            wr(A_IEN, {5'b0, 1'b1, sel});
            pulse_roll(rl);
            rd(A_STAT, v); check("R4 periodic flags", v, {2'b00, rl, 2'b00});
            @(negedge clk);
            check("R10 R7 period select irq", {7'b0, irq}, {7'b0, VEC[e][0]});
            wr(A_IEN, 8'h00);
            wr(A_STAT, 8'h3C);
            rd(A_STAT, v); check("R5 periodic clear", v, 8'h00);
            check("R9 irq low after mask", {7'b0, irq}, 8'h00);
        end

        // R3 alarm compare
        for (int i = 0; i < 6; i++) match_time[i*8 +: 8] = alm_val[i];
        now_time = match_time;
        now_time[47:40] = 8'h26;
        pulse_tick();
        rd(A_STAT, v); check("R3 year differs", v, 8'h00);
        now_time = match_time;
        repeat (2) @(negedge clk);
        rd(A_STAT, v); check("R3 match without tick", v, 8'h00);
        pulse_tick();
        rd(A_STAT, v); check("R3 match with tick", v, 8'h40);
        check("R9 flag set but masked", {7'b0, irq}, 8'h00);

        // R7, R8 enabled alarm
        wr(A_IEN, 8'h08);
        check("R7 irq lags enable", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R8 irq rises", {7'b0, irq}, 8'h01);
        repeat (5) @(negedge clk);
        check("R8 irq held", {7'b0, irq}, 8'h01);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v); check("R5 zero write no effect", v, 8'h40);

        // R9 mask keeps flag
        wr(A_IEN, 8'h00);
        @(negedge clk);
        check("R9 masked irq", {7'b0, irq}, 8'h00);
        rd(A_STAT, v); check("R9 flag kept", v, 8'h40);
        wr(A_IEN, 8'h08);
        @(negedge clk);
        check("R9 re-enable irq", {7'b0, irq}, 8'h01);

        // R8 clear drops the line one edge later
        wr(A_STAT, 8'h40);
        rd(A_STAT, v); check("R5 alarm cleared", v, 8'h00);
        check("R7 irq one edge late", {7'b0, irq}, 8'h01);
        @(negedge clk);
        check("R8 irq dropped", {7'b0, irq}, 8'h00);

        // R5 race: match and clear together
        @(negedge clk);
        tick = 1'b1; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h40;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        rd(A_STAT, v); check("R5 alarm event wins", v, 8'h40);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, v); check("R4 all clear", v, 8'h00);

        // R5 race: rollover and clear together
        @(negedge clk);
        roll_evt = 4'b0001; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h04;
        @(negedge clk);
        roll_evt = '0; bus_we = 1'b0;
        rd(A_STAT, v); check("R5 rollover wins", v, 8'h04);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule